// File: doc/BRIEF.md
# Processor flag register unit

This unit holds the status and control flags of a small 8/16-bit processor core and carries out every instruction whose only job is to change those flags. Each cycle it sees a decoded opcode byte with a valid strobe, an 8-bit immediate mask, and flag results from the arithmetic path, each with its own write enable. The arithmetic path decides which flags an instruction may touch: compares enable zero, negative, carry and overflow, while shifts and rotates enable only zero, negative and carry.

Eleven named flags each have a dedicated set opcode and a dedicated clear opcode. Three mask instructions act on the low byte: OR-set, clear-by-mask and a non-destructive test that reports through zero and carry. A halt opcode raises a sticky halt flag. For flag push the unit offers the whole flag word to the stack path together with a strobe, and for flag pop it loads the word back. The interrupt-enable, sound-interrupt-enable, debug and halt bits are brought out as separate outputs.

Flag word layout: bit 0 zero (Z), bit 1 negative (N), bit 2 carry (C), bit 3 overflow (V), bits 4 to 7 user flags E, F, B, U, bit 8 debug (D), bit 9 interrupt enable (I), bit 10 sound-interrupt enable (S), bit 11 halt (H), bits 15:12 reserved.

Top module: `cpu_flag_unit`

## Requirements
- R1: An active-low reset clears the whole flag word, and bits 15:12 always read as zero, whatever is popped.
- R2: With op_valid high, opcode 0xA0+k for k in 0..10 sets flag bit k (Z, N, C, V, E, F, B, U, D, I, S in that order) on the next clock edge and leaves the other bits unchanged.
- R3: With op_valid high, opcode 0xAB+k for k in 0..10 clears flag bit k on the next clock edge and leaves the other bits unchanged.
- R4: Opcode 0xB6 ORs op_mask into bits 7:0 and leaves bits 15:8 unchanged.
- R5: Opcode 0xB7 clears each bit of 7:0 whose op_mask bit is one and leaves bits 15:8 unchanged.
- R6: Opcode 0xB8 forms the AND of bits 7:0 with op_mask; Z becomes one when that AND is zero, C becomes one when it is nonzero, and every other bit is unchanged.
- R7: Opcode 0xFF sets H (bit 11) and the halt output; H then stays set until reset, and no pop or mask instruction can clear it.
- R8: When no flag instruction is executing, each of alu_we[3:0] (bit 0 Z, bit 1 N, bit 2 C, bit 3 V) that is one loads the matching alu_flags bit into that flag on the next edge; flags with a zero enable keep their value.
- R9: In a cycle where a valid flag instruction (0xA0 to 0xB8, 0xFF or 0x10) executes, all arithmetic flag updates are ignored.
- R10: Opcode 0x10 loads bits 10:0 of the flag word from pop_data[10:0] on the next edge.
- R11: push_stb is high in the same cycle as a valid opcode 0x0F and low otherwise, and push_data always shows the current flag word.
- R12: dbg_en, irq_en, snd_irq_en and halt show flag bits 8, 9, 10 and 11.
- R13: With op_valid low, or with any opcode not listed above, the opcode and mask leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies op_code for this cycle |
| op_code | input | 8 | Decoded opcode byte |
| op_mask | input | 8 | Immediate mask for the mask instructions |
| alu_we | input | 4 | Per-flag write enables from the arithmetic path (Z, N, C, V) |
| alu_flags | input | 4 | Flag results from the arithmetic path (Z, N, C, V) |
| pop_data | input | 16 | Flag word coming back from the stack path |
| push_stb | output | 1 | Flag push requested this cycle |
| push_data | output | 16 | Flag word offered to the stack path |
| flags_q | output | 16 | Current flag word |
| dbg_en | output | 1 | Debug flag |
| irq_en | output | 1 | Interrupt enable flag |
| snd_irq_en | output | 1 | Sound-interrupt enable flag |
| halt | output | 1 | Halt flag |

## Verification
The hardest situation to reach is a collision: a flag instruction arriving in the same cycle as arithmetic updates that would have written the same bits, combined with a flag word already holding a mix of ones and zeros, so that both the priority rule and the untouched bits show. The stimulus drives arithmetic enables and values at random on every cycle, including those that carry a set, clear, mask or pop opcode, so that collisions are frequent. Halt is kept rare in the random phase and then checked by a directed run of pops and mask clears after it.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int WORD_W  = 16;
    localparam int MASK_W  = 8;
    localparam int OP_W    = 8;
    localparam int NAMED_N = 11;
    localparam int ALU_N   = 4;
    localparam int H_POS   = 11;
    localparam int Z_POS   = 0;
    localparam int C_POS   = 2;
    localparam int RSVD_W  = WORD_W - H_POS - 1;

    localparam logic [OP_W-1:0] OP_SET_BASE  = 8'hA0;
    localparam logic [OP_W-1:0] OP_CLR_BASE  = OP_SET_BASE + OP_W'(NAMED_N);
    localparam logic [OP_W-1:0] OP_OR_MASK   = OP_CLR_BASE + OP_W'(NAMED_N);
    localparam logic [OP_W-1:0] OP_ANDN_MASK = OP_OR_MASK + 8'd1;
    localparam logic [OP_W-1:0] OP_TEST_MASK = OP_OR_MASK + 8'd2;
    localparam logic [OP_W-1:0] OP_HALT      = 8'hFF;
    localparam logic [OP_W-1:0] OP_PUSH      = 8'h0F;
    localparam logic [OP_W-1:0] OP_POP       = 8'h10;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic h;
        logic s;
        logic i;
        logic d;
        logic u;
        logic b;
        logic f;
        logic e;
        logic v;
        logic c;
        logic n;
        logic z;
    } flag_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] set_vec;
        logic [WORD_W-1:0] clr_vec;
        logic              or_en;
        logic              andn_en;
        logic              test_en;
        logic              pop_en;
        logic              push_en;
        logic              owns;
    } flagu_ctl_t;

endpackage

// File: rtl/flagu_decode.sv
module flagu_decode
    import flagu_pkg::*;
(
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    output flagu_ctl_t       ctl
);

    logic [WORD_W-1:0] set_v;
    logic [WORD_W-1:0] clr_v;

    // one set and one clear decoder per named flag
    for (genvar k = 0; k < NAMED_N; k++) begin : g_named
        assign set_v[k] = op_valid && (op_code == OP_SET_BASE + OP_W'(k));
        assign clr_v[k] = op_valid && (op_code == OP_CLR_BASE + OP_W'(k));
    end

    // halt and reserved bits have no named set or clear pair
    for (genvar k = NAMED_N; k < WORD_W; k++) begin : g_upper
        if (k == H_POS) begin : g_halt
            assign set_v[k] = op_valid && (op_code == OP_HALT);
        end else begin : g_rsvd
            assign set_v[k] = 1'b0;
        end
        assign clr_v[k] = 1'b0;
    end

    always_comb begin
        ctl.set_vec = set_v;
        ctl.clr_vec = clr_v;
        ctl.or_en   = op_valid && (op_code == OP_OR_MASK);
        ctl.andn_en = op_valid && (op_code == OP_ANDN_MASK);
        ctl.test_en = op_valid && (op_code == OP_TEST_MASK);
        ctl.pop_en  = op_valid && (op_code == OP_POP);
        ctl.push_en = op_valid && (op_code == OP_PUSH);
        ctl.owns    = (|set_v) || (|clr_v) || ctl.or_en || ctl.andn_en
                      || ctl.test_en || ctl.pop_en;
    end

endmodule

// File: rtl/flagu_maskop.sv
module flagu_maskop
    import flagu_pkg::*;
(
    input  logic [MASK_W-1:0] cur_low,
    input  logic [MASK_W-1:0] mask,
    input  logic              or_en,
    input  logic              andn_en,
    input  logic              test_en,
    output logic [MASK_W-1:0] new_low
);

    logic [MASK_W-1:0] overlap;

    always_comb begin
        overlap = cur_low & mask;
        new_low = cur_low;
        if (or_en) begin
            new_low = cur_low | mask;
        end else if (andn_en) begin
            new_low = cur_low & ~mask;
        end else if (test_en) begin
            new_low[Z_POS] = ~|overlap;
            new_low[C_POS] = |overlap;
        end
    end

endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit
    import flagu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [MASK_W-1:0] op_mask,
    input  logic [ALU_N-1:0]  alu_we,
    input  logic [ALU_N-1:0]  alu_flags,
    input  logic [WORD_W-1:0] pop_data,
    output logic              push_stb,
    output logic [WORD_W-1:0] push_data,
    output logic [WORD_W-1:0] flags_q,
    output logic              dbg_en,
    output logic              irq_en,
    output logic              snd_irq_en,
    output logic              halt
);

    flagu_ctl_t        ctl;
    flag_word_t        word_d;
    flag_word_t        word_q;
    logic [MASK_W-1:0] low_masked;

    flagu_decode u_decode (
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctl      (ctl)
    );

    flagu_maskop u_maskop (
        .cur_low  (word_q[MASK_W-1:0]),
        .mask     (op_mask),
        .or_en    (ctl.or_en),
        .andn_en  (ctl.andn_en),
        .test_en  (ctl.test_en),
        .new_low  (low_masked)
    );

    always_comb begin
        word_d = word_q;
        if (ctl.owns) begin
            // flag instructions win over the arithmetic path
            word_d = flag_word_t'((word_q | ctl.set_vec) & ~ctl.clr_vec);
            if (ctl.or_en || ctl.andn_en || ctl.test_en) begin
                word_d[MASK_W-1:0] = low_masked;
            end
            if (ctl.pop_en) begin
                word_d   = flag_word_t'(pop_data);
                word_d.h = word_q.h;
            end
        end else begin
            for (int j = 0; j < ALU_N; j++) begin
                if (alu_we[j]) begin
                    word_d[j] = alu_flags[j];
                end
            end
        end
        word_d.rsvd = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign flags_q    = word_q;
    assign push_data  = word_q;
    assign push_stb   = ctl.push_en;
    assign dbg_en     = word_q.d;
    assign irq_en     = word_q.i;
    assign snd_irq_en = word_q.s;
    assign halt       = word_q.h;

endmodule

// File: rtl/flagu_checker.sv
module flagu_checker
    import flagu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [MASK_W-1:0] op_mask,
    input logic [ALU_N-1:0]  alu_we,
    input logic [ALU_N-1:0]  alu_flags,
    input logic [WORD_W-1:0] pop_data,
    input logic [WORD_W-1:0] flags_q,
    input logic              halt
);

    logic [3:0] clr_idx;
    logic       is_set_op;
    logic       is_clr_op;

    assign clr_idx   = 4'(op_code - OP_CLR_BASE);
    assign is_set_op = op_valid && (op_code >= OP_SET_BASE) && (op_code < OP_CLR_BASE);
    assign is_clr_op = op_valid && (op_code >= OP_CLR_BASE) && (op_code < OP_OR_MASK);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[WORD_W-1:H_POS+1] == '0);

    assert_set_named_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_set_op |=> flags_q[$past(op_code[3:0])]);

    assert_clr_named_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr_op |=> !flags_q[$past(clr_idx)]);

    // also covers R9: arithmetic updates must not disturb the result
    assert_or_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_OR_MASK) |=>
        flags_q == ($past(flags_q) | {8'h00, $past(op_mask)}));

    assert_andn_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ANDN_MASK) |=>
        flags_q == ($past(flags_q) & ~{8'h00, $past(op_mask)}));

    assert_test_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TEST_MASK) |=>
        (flags_q[Z_POS] == ($past(flags_q[7:0] & op_mask) == 8'h00))
        && (flags_q[C_POS] != flags_q[Z_POS])
        && (flags_q[1] == $past(flags_q[1]))
        && (flags_q[WORD_W-1:3] == $past(flags_q[WORD_W-1:3])));

    assert_halt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_HALT) |=> halt);

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    for (genvar j = 0; j < ALU_N; j++) begin : g_alu
        assert_alu_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!op_valid && alu_we[j]) |=> flags_q[j] == $past(alu_flags[j]));
    end

    assert_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POP) |=>
        flags_q[H_POS-1:0] == $past(pop_data[H_POS-1:0]));

    assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && alu_we == '0) |=> $stable(flags_q));

endmodule

bind cpu_flag_unit flagu_checker u_flagu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_mask   (op_mask),
    .alu_we    (alu_we),
    .alu_flags (alu_flags),
    .pop_data  (pop_data),
    .flags_q   (flags_q),
    .halt      (halt)
);

// File: tb/tb_cpu_flag_unit.sv
`timescale 1ns/1ps
module tb_cpu_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [7:0]  op_mask;
    logic [3:0]  alu_we;
    logic [3:0]  alu_flags;
    logic [15:0] pop_data;
    logic        push_stb;
    logic [15:0] push_data;
    logic [15:0] flags_q;
    logic        dbg_en;
    logic        irq_en;
    logic        snd_irq_en;
    logic        halt;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = '0;

    always #2.5 clk = ~clk;

    cpu_flag_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_mask    (op_mask),
        .alu_we     (alu_we),
        .alu_flags  (alu_flags),
        .pop_data   (pop_data),
        .push_stb   (push_stb),
        .push_data  (push_data),
        .flags_q    (flags_q),
        .dbg_en     (dbg_en),
        .irq_en     (irq_en),
        .snd_irq_en (snd_irq_en),
        .halt       (halt)
    );

    function automatic logic [15:0] exp_next(logic [15:0] cur, logic v, logic [7:0] op,
                                             logic [7:0] m, logic [3:0] we, logic [3:0] af,
                                             logic [15:0] pop);
        logic [15:0] n;
        logic own;
        n   = cur;
        own = 1'b0;
        if (v) begin
            own = 1'b1;
            if (op >= 8'hA0 && op <= 8'hAA)      n[int'(op) - 'hA0] = 1'b1;
            else if (op >= 8'hAB && op <= 8'hB5) n[int'(op) - 'hAB] = 1'b0;
            else if (op == 8'hB6)                n[7:0] = cur[7:0] | m;
            else if (op == 8'hB7)                n[7:0] = cur[7:0] & ~m;
            else if (op == 8'hB8) begin
                n[0] = ((cur[7:0] & m) == 8'h00);
                n[2] = !n[0];
            end
            else if (op == 8'hFF)                n[11] = 1'b1;
            else if (op == 8'h10)                n = {4'h0, cur[11], pop[10:0]};
            else                                 own = 1'b0;
        end
        if (!own) begin
            for (int j = 0; j < 4; j++) if (we[j]) n[j] = af[j];
        end
        return n;
    endfunction

    function automatic string req_of(logic v, logic [7:0] op);
        if (!v)                              return "R8/R13";
        if (op >= 8'hA0 && op <= 8'hAA)      return "R2/R9";
        if (op >= 8'hAB && op <= 8'hB5)      return "R3/R9";
        if (op == 8'hB6)                     return "R4/R9";
        if (op == 8'hB7)                     return "R5/R9";
        if (op == 8'hB8)                     return "R6/R9";
        if (op == 8'hFF)                     return "R7";
        if (op == 8'h10)                     return "R10/R1";
        return "R8/R13";
    endfunction

    task automatic check(logic ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(logic v, logic [7:0] op, logic [7:0] m, logic [3:0] we,
                        logic [3:0] af, logic [15:0] pop);
        logic [15:0] e;
        op_valid  = v;
        op_code   = op;
        op_mask   = m;
        alu_we    = we;
        alu_flags = af;
        pop_data  = pop;
        #1;
        check(push_stb == (v && op == 8'h0F), "R11", 16'(push_stb), 16'(v && op == 8'h0F));
        check(push_data == model, "R11", push_data, model);
        e = exp_next(model, v, op, m, we, af, pop);
        @(negedge clk);
        check(flags_q == e, req_of(v, op), flags_q, e);
        check({halt, snd_irq_en, irq_en, dbg_en} == e[11:8], "R12",
              16'({halt, snd_irq_en, irq_en, dbg_en}), 16'(e[11:8]));
        model = e;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] op;
        void'($urandom(32'd2024));
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_mask = '0;
        alu_we = '0; alu_flags = '0; pop_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(flags_q == 16'h0000, "R1", flags_q, 16'h0000);
        check({halt, snd_irq_en, irq_en, dbg_en, push_stb} == 5'b0, "R1", 16'(halt), 16'h0);

        // R2 set each named flag while the arithmetic path tries to clear Z..V (R9)
        for (int k = 0; k < 11; k++) step(1'b1, 8'hA0 + 8'(k), 8'h00, 4'hF, 4'h0, 16'h0);
        step(1'b1, 8'h0F, 8'h00, 4'h0, 4'h0, 16'h0);            // R11 push of 0x07FF
        // R3 clear each named flag while the arithmetic path tries to set (R9)
        for (int k = 0; k < 11; k++) step(1'b1, 8'hAB + 8'(k), 8'h00, 4'hF, 4'hF, 16'h0);
        // R8 partial enables
        step(1'b0, 8'h00, 8'h00, 4'b0101, 4'b1111, 16'h0);
        step(1'b0, 8'h00, 8'h00, 4'b1010, 4'b1010, 16'h0);
        step(1'b0, 8'h00, 8'h00, 4'b0001, 4'b0000, 16'h0);
        // R4 / R5 with collisions
        step(1'b1, 8'hB6, 8'hA5, 4'hF, 4'h0, 16'h0);
        step(1'b1, 8'hB7, 8'h0F, 4'hF, 4'hF, 16'h0);
        // R6 disjoint then overlapping mask
        step(1'b1, 8'hB8, 8'h0A, 4'hF, 4'hF, 16'h0);
        step(1'b1, 8'hB8, 8'h80, 4'h0, 4'h0, 16'h0);
        // R10 pop of all ones, reserved and halt stay clear (R1)
        step(1'b1, 8'h10, 8'h00, 4'hF, 4'h0, 16'hFFFF);
        // R13 invalid opcode and unrelated opcode
        step(1'b0, 8'hAB, 8'hFF, 4'h0, 4'h0, 16'h0);
        step(1'b1, 8'hFE, 8'hFF, 4'h0, 4'h0, 16'h0);
        step(1'b1, 8'hFE, 8'hFF, 4'b1000, 4'b0000, 16'h0);
        step(1'b1, 8'h10, 8'h00, 4'h0, 4'h0, 16'h0000);

        // random phase, halt kept rare
        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 8)
                0: op = 8'hA0 + 8'($urandom % 11);
                1: op = 8'hAB + 8'($urandom % 11);
                2: op = 8'hB6 + 8'($urandom % 3);
                3: op = ($urandom % 2) ? 8'h0F : 8'h10;
                4: op = 8'($urandom);
                5: op = 8'hFE;
                6: op = (($urandom % 64) == 0) ? 8'hFF : 8'hB6;
                default: op = 8'hB8;
            endcase
            if (op == 8'hFF && n < 2500) op = 8'hFE;
            step(($urandom % 8) != 0, op, 8'($urandom), 4'($urandom), 4'($urandom), 16'($urandom));
        end

        // R7 halt, then attempts to clear it
        step(1'b1, 8'hFF, 8'h00, 4'h0, 4'h0, 16'h0);
        step(1'b1, 8'h10, 8'h00, 4'h0, 4'h0, 16'h0000);
        step(1'b1, 8'hB7, 8'hFF, 4'h0, 4'h0, 16'h0);
        step(1'b1, 8'hB3, 8'h00, 4'h0, 4'h0, 16'h0);
        step(1'b0, 8'h00, 8'h00, 4'hF, 4'h5, 16'h0);
        check(halt == 1'b1, "R7", 16'(halt), 16'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule